// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recently used page translations. Each translation pairs a virtual page number and an 8-bit process identifier with a physical page number and three access permissions. Every entry is compared with a lookup at the same time. The result of a lookup appears combinationally in the same cycle. The page offset passes through untranslated and is joined to the stored physical page number.

A lookup reports one of three outcomes. A hit means the address is translated. A miss means that no matching translation is present, so an external page walker must supply one through the fill port. A protection fault means that a translation was found but it does not permit the requested kind of access. The identifier of the current process is an input, so translations that belong to different processes can be held at the same time across context switches. A flush input invalidates the whole store in one cycle.

When a new translation arrives, it is written to the first place found in this order:
1. the entry that already holds the same page and process;
2. otherwise, the lowest-numbered free entry;
3. otherwise, the entry named by a round-robin victim pointer.

Top module: `xlat_cache`

## Requirements
- R1: After reset, every entry is invalid, so any lookup reports a miss.
- R2: A lookup hits only when a valid entry matches both its virtual page number (`lk_vaddr[31:16]`) and `cur_pid`. On a hit, `paddr` is the stored page number in bits 27:16 and `lk_vaddr[15:0]` unchanged in bits 15:0, all in the same cycle.
- R3: An entry whose page number matches but whose process identifier differs is not used, and the lookup reports a miss.
- R4: The access code on `lk_acc` is 0 for a read, 1 for a write, 2 for an instruction fetch, and 3 for a reserved code. The permission field is bit 0 = read, bit 1 = write, bit 2 = execute. A matching entry that does not allow the access reports `fault` instead of `hit`, with `paddr` zero. Code 3 always faults.
- R5: When `lk_valid` is high, exactly one of `hit`, `miss` and `fault` is high.
- R6: A fill whose page and process already exist overwrites that entry and does not take a second slot.
- R7: A fill with no existing match goes to the lowest-numbered invalid entry. When no entry is invalid, it goes to the victim pointer. The pointer starts at 0 after reset and advances by one, wrapping at the last entry, only when it was used.
- R8: A flush invalidates every entry at the next clock edge. A fill in the same cycle as a flush is dropped.
- R9: When `lk_valid` is low, `hit`, `miss`, `fault` and `paddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access code (0 read, 1 write, 2 fetch, 3 reserved) |
| cur_pid | input | 8 | Identifier of the running process |
| hit | output | 1 | Translation found and access allowed |
| miss | output | 1 | No translation; a fill is needed |
| fault | output | 1 | Translation found but access not allowed |
| paddr | output | 28 | Physical address on a hit, else zero |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpn | input | 16 | Virtual page number to store |
| fill_pid | input | 8 | Process identifier to store |
| fill_ppn | input | 12 | Physical page number to store |
| fill_perm | input | 3 | Permissions to store (bit 0 read, bit 1 write, bit 2 execute) |
| flush | input | 1 | Invalidate all entries |

## Verification
The hardest case to reach from the ports is eviction by the victim pointer. Eviction happens only when no entry is free. The slot the pointer selects is not visible at the ports.

The stimulus fills the store to exactly its capacity, so the slot of every entry is known from the lowest-free rule. Along the way it includes an overwrite that must not use up a slot. Two further fills must then push out the entries in slots 0 and 1, in that order. Lookups of the evicted and surviving translations show at the ports which slots were replaced.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // bit 0 read, bit 1 write, bit 2 execute
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    function automatic logic perm_allows(perm_t p, logic [1:0] acc);
        logic ok;
        case (acc_e'(acc))
            ACC_LOAD:  ok = p.r;
            ACC_STORE: ok = p.w;
            ACC_FETCH: ok = p.x;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int N     = 16,
    parameter int VPN_W = 16,
    parameter int PID_W = 8
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][VPN_W-1:0] tag_vpn,
    input  logic [N-1:0][PID_W-1:0] tag_pid,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [PID_W-1:0]        key_pid,
    output logic [N-1:0]            hit_vec
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = vld[i] && (tag_vpn[i] == key_vpn) && (tag_pid[i] == key_pid);
    end

endmodule

// File: rtl/xlat_alloc.sv
module xlat_alloc #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     vld,
    input  logic [N-1:0]     dup_vec,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] slot,
    output logic             from_ptr
);

    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        dup_idx  = '0;
        free_idx = '0;
        any_free = 1'b0;
        // scan downward so the lowest index wins
        for (int i = N - 1; i >= 0; i--) begin
            if (dup_vec[i]) begin
                dup_idx = IDX_W'(i);
            end
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        if (|dup_vec) begin
            slot     = dup_idx;
            from_ptr = 1'b0;
        end else if (any_free) begin
            slot     = free_idx;
            from_ptr = 1'b0;
        end else begin
            slot     = ptr;
            from_ptr = 1'b1;
        end
    end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 28,
    parameter int OFS_W   = 16,
    parameter int PID_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_valid,
    input  logic [VA_W-1:0]         lk_vaddr,
    input  logic [1:0]              lk_acc,
    input  logic [PID_W-1:0]        cur_pid,
    output logic                    hit,
    output logic                    miss,
    output logic                    fault,
    output logic [PA_W-1:0]         paddr,
    input  logic                    fill_valid,
    input  logic [VA_W-OFS_W-1:0]   fill_vpn,
    input  logic [PID_W-1:0]        fill_pid,
    input  logic [PA_W-OFS_W-1:0]   fill_ppn,
    input  logic [2:0]              fill_perm,
    input  logic                    flush
);

    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PID_W-1:0] pid;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        perm_t [ENTRIES-1:0]           perm;
        logic [IDX_W-1:0]              ptr;
    } state_t;

    state_t st_q, st_d;

    logic [VPN_W-1:0]   lk_vpn;
    logic [OFS_W-1:0]   lk_ofs;
    logic [ENTRIES-1:0] lk_hit_vec;
    logic [ENTRIES-1:0] fill_dup_vec;
    logic [IDX_W-1:0]   fill_slot;
    logic               fill_from_ptr;
    logic [PPN_W-1:0]   sel_ppn;
    perm_t              sel_perm;
    logic               any_match;
    logic               allowed;

    assign lk_vpn = lk_vaddr[VA_W-1:OFS_W];
    assign lk_ofs = lk_vaddr[OFS_W-1:0];

    // lookup compare against every entry
    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) lk_match_i (
        .vld     (st_q.valid),
        .tag_vpn (st_q.vpn),
        .tag_pid (st_q.pid),
        .key_vpn (lk_vpn),
        .key_pid (cur_pid),
        .hit_vec (lk_hit_vec)
    );

    // fill-side compare to find an entry to overwrite
    xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) fill_match_i (
        .vld     (st_q.valid),
        .tag_vpn (st_q.vpn),
        .tag_pid (st_q.pid),
        .key_vpn (fill_vpn),
        .key_pid (fill_pid),
        .hit_vec (fill_dup_vec)
    );

    xlat_alloc #(.N(ENTRIES), .IDX_W(IDX_W)) alloc_i (
        .vld      (st_q.valid),
        .dup_vec  (fill_dup_vec),
        .ptr      (st_q.ptr),
        .slot     (fill_slot),
        .from_ptr (fill_from_ptr)
    );

    // read side: matches are unique, so an OR-select is enough
    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i]) begin
                sel_ppn  = sel_ppn | st_q.ppn[i];
                sel_perm = sel_perm | st_q.perm[i];
            end
        end
        any_match = |lk_hit_vec;
        allowed   = perm_allows(sel_perm, lk_acc);
        hit       = lk_valid && any_match && allowed;
        fault     = lk_valid && any_match && !allowed;
        miss      = lk_valid && !any_match;
        paddr     = hit ? {sel_ppn, lk_ofs} : '0;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_valid) begin
            st_d.valid[fill_slot] = 1'b1;
            st_d.vpn[fill_slot]   = fill_vpn;
            st_d.pid[fill_slot]   = fill_pid;
            st_d.ppn[fill_slot]   = fill_ppn;
            st_d.perm[fill_slot]  = perm_t'(fill_perm);
            if (fill_from_ptr) begin
                st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 28,
    parameter int OFS_W = 16,
    parameter int PID_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lk_valid,
    input logic [VA_W-1:0]       lk_vaddr,
    input logic [PID_W-1:0]      cur_pid,
    input logic                  hit,
    input logic                  miss,
    input logic                  fault,
    input logic [PA_W-1:0]       paddr,
    input logic                  fill_valid,
    input logic [VA_W-OFS_W-1:0] fill_vpn,
    input logic [PID_W-1:0]      fill_pid,
    input logic                  flush
);

    // R5
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({hit, miss, fault}) == 1);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!hit && !miss && !fault && paddr == '0));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]);

    // R4
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> paddr == '0);

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_valid || miss));

    // R6
    fill_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=>
            (!lk_valid || lk_vaddr[VA_W-1:OFS_W] != $past(fill_vpn)
             || cur_pid != $past(fill_pid) || !miss));

endmodule

bind xlat_cache xlat_cache_chk #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .OFS_W(OFS_W),
    .PID_W(PID_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .cur_pid    (cur_pid),
    .hit        (hit),
    .miss       (miss),
    .fault      (fault),
    .paddr      (paddr),
    .fill_valid (fill_valid),
    .fill_vpn   (fill_vpn),
    .fill_pid   (fill_pid),
    .flush      (flush)
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic [7:0]  cur_pid = '0;
    logic        hit, miss, fault;
    logic [27:0] paddr;
    logic        fill_valid = 1'b0;
    logic [15:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [11:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .cur_pid(cur_pid),
        .hit(hit), .miss(miss), .fault(fault), .paddr(paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm), .flush(flush)
    );

    typedef struct packed {
        logic        h;
        logic        m;
        logic        f;
        logic [27:0] pa;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    // monitor: compare in the middle of the cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({hit, miss, fault, paddr} !== e) begin
                fails++;
                $display("FAIL %s: got hit=%0b miss=%0b fault=%0b paddr=%h, expected hit=%0b miss=%0b fault=%0b paddr=%h",
                         t, hit, miss, fault, paddr, e.h, e.m, e.f, e.pa);
            end
        end
    end

    task automatic quiet();
        lk_valid   = 1'b0;
        fill_valid = 1'b0;
        flush      = 1'b0;
    endtask

    task automatic do_fill(input logic [15:0] vpn, input logic [7:0] pid,
                           input logic [11:0] ppn, input logic [2:0] perm,
                           input logic with_flush);
        @(posedge clk); #1;
        quiet();
        fill_valid = 1'b1;
        fill_vpn   = vpn;
        fill_pid   = pid;
        fill_ppn   = ppn;
        fill_perm  = perm;
        flush      = with_flush;
    endtask

    task automatic do_flush();
        @(posedge clk); #1;
        quiet();
        flush = 1'b1;
    endtask

    task automatic look(input logic v, input logic [31:0] va, input logic [1:0] acc,
                        input logic [7:0] pid, input logic eh, input logic em,
                        input logic ef, input logic [27:0] epa, input string tag);
        exp_t e;
        @(posedge clk); #1;
        quiet();
        lk_valid = v;
        lk_vaddr = va;
        lk_acc   = acc;
        cur_pid  = pid;
        e.h = eh; e.m = em; e.f = ef; e.pa = epa;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        look(1, 32'h1234_5678, 2'd0, 8'd1, 0, 1, 0, '0, "R1 miss after reset");
        // R9: no request, no outputs
        look(0, 32'h1234_5678, 2'd0, 8'd1, 0, 0, 0, '0, "R9 idle lookup");

        do_fill(16'h1234, 8'd1, 12'hABC, 3'b011, 0);
        look(1, 32'h1234_5678, 2'd0, 8'd1, 1, 0, 0, {12'hABC, 16'h5678}, "R2 read hit");
        look(1, 32'h1234_0001, 2'd1, 8'd1, 1, 0, 0, {12'hABC, 16'h0001}, "R2 write hit");
        look(1, 32'h1234_5678, 2'd2, 8'd1, 0, 0, 1, '0, "R4 fetch without execute");
        look(1, 32'h1234_5678, 2'd3, 8'd1, 0, 0, 1, '0, "R4 reserved code");
        look(1, 32'h1234_5678, 2'd0, 8'd2, 0, 1, 0, '0, "R3 other process");
        look(0, 32'h1234_5678, 2'd0, 8'd1, 0, 0, 0, '0, "R9 idle with match present");

        do_fill(16'h1234, 8'd2, 12'h111, 3'b100, 0);
        look(1, 32'h1234_FFFF, 2'd2, 8'd2, 1, 0, 0, {12'h111, 16'hFFFF}, "R3 second process fetch");
        look(1, 32'h1234_FFFF, 2'd0, 8'd2, 0, 0, 1, '0, "R4 execute-only read");
        look(1, 32'h1234_5678, 2'd1, 8'd1, 1, 0, 0, {12'hABC, 16'h5678}, "R5 first process intact");

        // R6: overwrite same page/process
        do_fill(16'h1234, 8'd1, 12'h222, 3'b111, 0);
        look(1, 32'h1234_5678, 2'd2, 8'd1, 1, 0, 0, {12'h222, 16'h5678}, "R6 overwrite");

        // fill slots 2..15
        for (int i = 0; i < 14; i++) begin
            do_fill(16'h0100 + 16'(i), 8'd3, 12'(i + 1), 3'b001, 0);
        end
        for (int i = 0; i < 14; i++) begin
            look(1, {16'h0100 + 16'(i), 16'h0042}, 2'd0, 8'd3, 1, 0, 0,
                 {12'(i + 1), 16'h0042}, "R6 all slots retained");
        end
        look(1, 32'h1234_0000, 2'd0, 8'd1, 1, 0, 0, {12'h222, 16'h0000}, "R6 slot0 retained");
        look(1, 32'h1234_0000, 2'd2, 8'd2, 1, 0, 0, {12'h111, 16'h0000}, "R6 slot1 retained");

        // R7: full, victim pointer at slot 0
        do_fill(16'h0200, 8'd3, 12'hF00, 3'b001, 0);
        look(1, 32'h1234_0000, 2'd0, 8'd1, 0, 1, 0, '0, "R7 slot0 evicted");
        look(1, 32'h1234_0000, 2'd2, 8'd2, 1, 0, 0, {12'h111, 16'h0000}, "R7 slot1 survives");
        look(1, 32'h0200_1234, 2'd0, 8'd3, 1, 0, 0, {12'hF00, 16'h1234}, "R7 new entry");
        do_fill(16'h0201, 8'd3, 12'hF01, 3'b001, 0);
        look(1, 32'h1234_0000, 2'd2, 8'd2, 0, 1, 0, '0, "R7 slot1 evicted next");
        look(1, 32'h0100_0000, 2'd0, 8'd3, 1, 0, 0, {12'h001, 16'h0000}, "R7 slot2 survives");

        // R8: flush together with a fill
        do_fill(16'h0300, 8'd3, 12'h333, 3'b001, 1);
        look(1, 32'h0200_0000, 2'd0, 8'd3, 0, 1, 0, '0, "R8 flushed entry");
        look(1, 32'h0300_0000, 2'd0, 8'd3, 0, 1, 0, '0, "R8 fill dropped");
        look(1, 32'h0100_0000, 2'd0, 8'd3, 0, 1, 0, '0, "R8 all cleared");
        do_fill(16'h0400, 8'd5, 12'h444, 3'b010, 0);
        look(1, 32'h0400_0010, 2'd1, 8'd5, 1, 0, 0, {12'h444, 16'h0010}, "R8 usable after flush");
        do_flush();
        look(1, 32'h0400_0010, 2'd1, 8'd5, 0, 1, 0, '0, "R8 plain flush");

        @(posedge clk); #1; quiet();
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule